// File: doc/BRIEF.md
# Programmable Bank Chip-Select Decoder

This block sits between a processor's 32-bit byte-addressed bus and the external memory pins. When a request is valid, it sorts the address into one of three groups. The first is eight external banks, each with an active-low chip select. The second is two internal regions: a 4 KB on-chip SRAM and a special-function register space. The third is unmapped space. The result appears one clock later as a chip-select vector, a region code and the bank-internal address that goes to the memory devices.

The lowest six banks are fixed 128 MB windows. The top two banks share one programmable size, set by a 3-bit code written through a small configuration port. The upper bank always begins where the one below it ends, so the decode of both upper banks shifts when the code changes. Any address inside the upper 256 MB span that lies beyond the two sized banks decodes as unmapped.

Top module: `bank_cs_decoder`

## Requirements
- R1: Outputs are registered. A request presented with `req_valid` high shows its result one clock later with `out_valid` high. A cycle with `req_valid` low gives, one clock later, `out_valid` low, all `cs_n` high, `region` = 0 and `ext_addr` = 0. The same values hold while `rst_n` is low.
- R2: For an address below 0x3000_0000, the bank is addr[29:27] (0..5). `cs_n[bank]` goes low, `region` = 1 (bank) and `ext_addr` = addr[26:0].
- R3: The upper-bank size code c on `cfg_size` selects a size of (2 MB << c) for c = 0..6. The code resets to 6 (128 MB). It is loaded on a clock with `cfg_we` high, takes effect for requests presented on later cycles, and code 7 is ignored so the previous size stays in force.
- R4: With size S and offset d = addr − 0x3000_0000, an address with d < S asserts `cs_n[6]`, gives `region` = 1 and gives `ext_addr` = d.
- R5: An address with S ≤ d < 2S asserts `cs_n[7]`, gives `region` = 1 and gives `ext_addr` = d − S.
- R6: An address in 0x3000_0000..0x3FFF_FFFF with d ≥ 2S asserts no chip select, gives `region` = 0 (unmapped) and gives `ext_addr` = 0.
- R7: 0x4000_0000..0x4000_0FFF gives `region` = 2 (internal SRAM), no chip select, and `ext_addr` = addr[26:0].
- R8: 0x4000_1000..0x47FF_FFFF gives `region` = 0, no chip select and `ext_addr` = 0.
- R9: 0x4800_0000..0x5FFF_FFFF gives `region` = 3 (register space), no chip select, and `ext_addr` = addr[26:0].
- R10: Addresses at or above 0x6000_0000 give `region` = 0, no chip select and `ext_addr` = 0.
- R11: At most one `cs_n` bit is low at any time, and none is low unless `region` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address on `req_addr` is a valid request this cycle |
| req_addr | input | 32 | Processor byte address |
| cfg_we | input | 1 | Load `cfg_size` into the upper-bank size register |
| cfg_size | input | 3 | Upper-bank size code (2 MB << code, 7 ignored) |
| cs_n | output | 8 | Active-low external bank chip selects |
| ext_addr | output | 27 | Bank-internal address driven to external memory |
| region | output | 2 | 0 none/unmapped, 1 external bank, 2 internal SRAM, 3 register space |
| out_valid | output | 1 | Registered outputs carry a decoded request |

## Verification
The bench builds the block with its default parameters: eight banks, a 27-bit bank address and a reset size code of 6. With these values, the 128 MB upper-bank boundary at 0x3800_0000 coincides with the plain bit-field decode. Size codes 0, 3 and 5 are then written during the run. These move the bank 7 base to 0x3020_0000, 0x3100_0000 and 0x3400_0000, and they open an unmapped tail inside the upper span. A rejected code 7 is also tested: bank placement must be unchanged after it.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int          SIZE_W        = 3;
  localparam int          MIN_SIZE_LOG2 = 21;
  localparam int          SRAM_AW       = 12;
  localparam logic [31:0] SRAM_BASE     = 32'h4000_0000;
  localparam logic [31:0] SFR_BASE      = 32'h4800_0000;
  localparam logic [31:0] SFR_END       = 32'h6000_0000;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_BANK = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_SFR  = 2'd3
  } region_e;

  // Size in bytes of each upper bank for a size code.
  function automatic logic [31:0] upper_bytes(input logic [SIZE_W-1:0] code);
    return 32'd1 << (MIN_SIZE_LOG2 + int'(code));
  endfunction

  // Codes above the largest legal one are rejected.
  function automatic logic code_legal(input logic [SIZE_W-1:0] code,
                                      input logic [SIZE_W-1:0] max_code);
    return code <= max_code;
  endfunction
endpackage

// File: rtl/bcd_size_reg.sv
module bcd_size_reg
  import bcd_pkg::*;
#(
  parameter logic [SIZE_W-1:0] RST_CODE = 3'd6,
  parameter logic [SIZE_W-1:0] MAX_CODE = 3'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIZE_W-1:0] wr_code,
  output logic [SIZE_W-1:0] size_code,
  output logic              wr_taken
);
  assign wr_taken = wr_en && code_legal(wr_code, MAX_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        size_code <= RST_CODE;
    else if (wr_taken) size_code <= wr_code;
  end
endmodule

// File: rtl/bcd_addr_decode.sv
module bcd_addr_decode
  import bcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_AW   = 27
) (
  input  logic [31:0]          addr,
  input  logic [SIZE_W-1:0]    size_code,
  output logic [NUM_BANKS-1:0] sel,
  output region_e              rgn,
  output logic [BANK_AW-1:0]   offs
);
  localparam int SEL_W     = $clog2(NUM_BANKS);
  localparam int NUM_FIXED = NUM_BANKS - 2;
  localparam int EXT_TOP   = BANK_AW + SEL_W;

  typedef logic [BANK_AW:0]   off_t;
  typedef logic [BANK_AW+1:0] span_t;

  logic             ext_space, upper, fixed_hit;
  logic             in_lo_up, in_hi_up, past_end;
  logic             sram_hit, sfr_hit;
  logic [SEL_W-1:0] bank_f;
  off_t             up_off;
  span_t            sz;

  // The upper span starts at a power-of-two multiple of the bank size, so
  // the offset into it is just the low address bits.
  assign ext_space = (addr[31:EXT_TOP] == '0);
  assign bank_f    = addr[BANK_AW +: SEL_W];
  assign upper     = ext_space && (bank_f >= SEL_W'(NUM_FIXED));
  assign fixed_hit = ext_space && !upper;
  assign up_off    = addr[BANK_AW:0];
  assign sz        = span_t'(upper_bytes(size_code));

  assign in_lo_up  = upper && (span_t'(up_off) < sz);
  assign in_hi_up  = upper && !in_lo_up && (span_t'(up_off) < (sz << 1));
  assign past_end  = upper && !in_lo_up && !in_hi_up;

  assign sram_hit  = (addr[31:SRAM_AW] == SRAM_BASE[31:SRAM_AW]);
  assign sfr_hit   = (addr >= SFR_BASE) && (addr < SFR_END);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    if (i < NUM_FIXED) begin : g_fixed
      assign sel[i] = fixed_hit && (bank_f == SEL_W'(i));
    end else if (i == NUM_FIXED) begin : g_lo_up
      assign sel[i] = in_lo_up;
    end else begin : g_hi_up
      assign sel[i] = in_hi_up;
    end
  end

  always_comb begin
    rgn  = RGN_NONE;
    offs = '0;
    if (fixed_hit) begin
      rgn  = RGN_BANK;
      offs = addr[BANK_AW-1:0];
    end else if (in_lo_up || in_hi_up) begin
      // Masking by the size removes the base of the higher bank.
      rgn  = RGN_BANK;
      offs = BANK_AW'(span_t'(up_off) & (sz - span_t'(1)));
    end else if (past_end) begin
      rgn  = RGN_NONE;
    end else if (sram_hit) begin
      rgn  = RGN_SRAM;
      offs = addr[BANK_AW-1:0];
    end else if (sfr_hit) begin
      rgn  = RGN_SFR;
      offs = addr[BANK_AW-1:0];
    end
  end
endmodule

// File: rtl/bcd_out_reg.sv
module bcd_out_reg
  import bcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_AW   = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NUM_BANKS-1:0] sel,
  input  region_e              rgn,
  input  logic [BANK_AW-1:0]   offs,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic [BANK_AW-1:0]   ext_addr,
  output logic [1:0]           region,
  output logic                 out_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= '1;
      ext_addr  <= '0;
      region    <= RGN_NONE;
      out_valid <= 1'b0;
    end else if (in_valid) begin
      cs_n      <= ~sel;
      ext_addr  <= offs;
      region    <= rgn;
      out_valid <= 1'b1;
    end else begin
      cs_n      <= '1;
      ext_addr  <= '0;
      region    <= RGN_NONE;
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
  import bcd_pkg::*;
#(
  parameter int                NUM_BANKS = 8,
  parameter int                BANK_AW   = 27,
  parameter logic [SIZE_W-1:0] SIZE_RST  = 3'd6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic                 cfg_we,
  input  logic [SIZE_W-1:0]    cfg_size,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic [BANK_AW-1:0]   ext_addr,
  output logic [1:0]           region,
  output logic                 out_valid
);
  localparam logic [SIZE_W-1:0] MAX_CODE = SIZE_W'(BANK_AW - MIN_SIZE_LOG2);

  logic [SIZE_W-1:0]    size_code;
  logic                 size_wr_taken;
  logic [NUM_BANKS-1:0] dec_sel;
  region_e              dec_rgn;
  logic [BANK_AW-1:0]   dec_offs;

  bcd_size_reg #(.RST_CODE(SIZE_RST), .MAX_CODE(MAX_CODE)) size_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_code  (cfg_size),
    .size_code(size_code),
    .wr_taken (size_wr_taken)
  );

  bcd_addr_decode #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) dec_i (
    .addr     (req_addr),
    .size_code(size_code),
    .sel      (dec_sel),
    .rgn      (dec_rgn),
    .offs     (dec_offs)
  );

  bcd_out_reg #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) oreg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .sel      (dec_sel),
    .rgn      (dec_rgn),
    .offs     (dec_offs),
    .cs_n     (cs_n),
    .ext_addr (ext_addr),
    .region   (region),
    .out_valid(out_valid)
  );
endmodule

// File: rtl/bcd_chk.sv
module bcd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        cfg_we,
  input logic [2:0]  cfg_size,
  input logic        size_wr_taken,
  input logic [7:0]  cs_n,
  input logic [26:0] ext_addr,
  input logic [1:0]  region,
  input logic        out_valid
);
  // R1
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && (&cs_n) && region == 2'd0 && ext_addr == '0));

  // R2
  fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:30] == 2'b00 && req_addr[29:28] != 2'b11)
    |=> ((~cs_n) == (8'd1 << $past(req_addr[29:27])) &&
         ext_addr == $past(req_addr[26:0]) && region == 2'd1));

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_size == 3'd7) |-> !size_wr_taken);

  // R9
  sfr_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= 32'h4800_0000 && req_addr < 32'h6000_0000)
    |=> (region == 2'd3 && (&cs_n)));

  // R10
  high_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= 32'h6000_0000) |=> (region == 2'd0 && (&cs_n)));

  // R11
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R11
  cs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region != 2'd1) |-> (&cs_n));
endmodule

bind bank_cs_decoder bcd_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .cfg_we       (cfg_we),
  .cfg_size     (cfg_size),
  .size_wr_taken(size_wr_taken),
  .cs_n         (cs_n),
  .ext_addr     (ext_addr),
  .region       (region),
  .out_valid    (out_valid)
);

// File: tb/bank_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module bank_cs_decoder_tb_top;
  typedef struct packed {
    logic [7:0]  cs_n;
    logic [26:0] ext;
    logic [1:0]  rgn;
    logic        vld;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_size = '0;
  logic [7:0]  cs_n;
  logic [26:0] ext_addr;
  logic [1:0]  region;
  logic        out_valid;

  int    checks = 0;
  int    failures = 0;
  int    model_code = 6;
  bit    finished = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  bank_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_size(cfg_size), .cs_n(cs_n), .ext_addr(ext_addr),
    .region(region), .out_valid(out_valid)
  );

  // Reference decode, written from the address map.
  function automatic exp_t model(input logic [31:0] a, input bit v, input int code);
    exp_t e;
    longint unsigned sz, ad, d;
    e = '{cs_n: 8'hFF, ext: '0, rgn: 2'd0, vld: v};
    if (!v) return e;
    sz = 64'd2097152 << code;
    ad = longint'(a);
    if (ad < 64'h3000_0000) begin
      e.cs_n = ~(8'd1 << (ad / 64'h800_0000));
      e.ext  = 27'(ad % 64'h800_0000);
      e.rgn  = 2'd1;
    end else if (ad < 64'h4000_0000) begin
      d = ad - 64'h3000_0000;
      if (d < sz) begin
        e.cs_n = 8'hBF; e.ext = 27'(d); e.rgn = 2'd1;
      end else if (d < 2 * sz) begin
        e.cs_n = 8'h7F; e.ext = 27'(d - sz); e.rgn = 2'd1;
      end
    end else if (ad < 64'h4000_1000) begin
      e.rgn = 2'd2; e.ext = 27'(ad - 64'h4000_0000);
    end else if (ad < 64'h4800_0000) begin
      e.rgn = 2'd0;
    end else if (ad < 64'h6000_0000) begin
      e.rgn = 2'd3; e.ext = 27'(ad % 64'h800_0000);
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input bit v, input string tag);
    @(negedge clk);
    req_valid = v;
    req_addr  = a;
    cfg_we    = 1'b0;
    exp_q.push_back(model(a, v, model_code));
    tag_q.push_back(tag);
  endtask

  task automatic set_size(input logic [2:0] code);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b1;
    cfg_size  = code;
    exp_q.push_back(model('0, 1'b0, model_code));
    tag_q.push_back("R3 cfg cycle");
    if (code <= 3'd6) model_code = int'(code);
  endtask

  // Monitor: each result appears one edge after its request.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  got;
      string t;
      #1;
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      got = '{cs_n: cs_n, ext: ext_addr, rgn: region, vld: out_valid};
      checks++;
      if (got !== e) begin
        failures++;
        $display("FAIL %s: cs_n=%h ext=%h rgn=%0d vld=%0b expected cs_n=%h ext=%h rgn=%0d vld=%0b",
                 t, got.cs_n, got.ext, got.rgn, got.vld, e.cs_n, e.ext, e.rgn, e.vld);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (cs_n !== 8'hFF || out_valid !== 1'b0 || region !== 2'd0 || ext_addr !== '0) begin
      failures++;
      $display("FAIL R1 reset: cs_n=%h vld=%0b rgn=%0d ext=%h expected cs_n=ff vld=0 rgn=0 ext=0",
               cs_n, out_valid, region, ext_addr);
    end
    rst_n = 1'b1;
    drive(32'h0, 1'b0, "R1 idle");
    drive(32'h0000_0000, 1'b1, "R2 bank0 base");
    drive(32'h0812_3456, 1'b1, "R2 bank1");
    drive(32'h1000_0004, 1'b1, "R2 bank2");
    drive(32'h2800_0000, 1'b0, "R1 invalid addr ignored");
    drive(32'h2800_0000, 1'b1, "R2 bank5 base");
    drive(32'h2FFF_FFFF, 1'b1, "R2 bank5 top");
    drive(32'h3000_0010, 1'b1, "R4 bank6 reset size");
    drive(32'h37FF_FFFF, 1'b1, "R4 bank6 top 128MB");
    drive(32'h3800_0000, 1'b1, "R5 bank7 base 128MB");
    drive(32'h3FFF_FFFC, 1'b1, "R5 bank7 top 128MB");
    set_size(3'd0);
    drive(32'h3000_0000, 1'b1, "R4 bank6 2MB base");
    drive(32'h301F_FFFF, 1'b1, "R4 bank6 2MB top");
    drive(32'h3020_0000, 1'b1, "R5 bank7 2MB base");
    drive(32'h303F_FFFF, 1'b1, "R5 bank7 2MB top");
    drive(32'h3040_0000, 1'b1, "R6 past end 2MB");
    drive(32'h3800_0000, 1'b1, "R6 far past end 2MB");
    set_size(3'd3);
    drive(32'h30FF_FFFF, 1'b1, "R4 bank6 16MB top");
    drive(32'h3100_0000, 1'b1, "R5 bank7 16MB base");
    drive(32'h3200_0000, 1'b1, "R6 past end 16MB");
    set_size(3'd7);
    drive(32'h3100_0000, 1'b1, "R3 code 7 ignored bank7");
    drive(32'h3200_0000, 1'b1, "R3 code 7 ignored past end");
    set_size(3'd5);
    drive(32'h3400_0010, 1'b1, "R5 bank7 64MB");
    drive(32'h33FF_FFFF, 1'b1, "R4 bank6 64MB top");
    drive(32'h3800_0000, 1'b1, "R6 past end 64MB");
    drive(32'h4000_0000, 1'b1, "R7 sram base");
    drive(32'h4000_0FFF, 1'b1, "R7 sram top");
    drive(32'h4000_1000, 1'b1, "R8 gap base");
    drive(32'h47FF_FFFF, 1'b1, "R8 gap top");
    drive(32'h4800_0000, 1'b1, "R9 sfr base");
    drive(32'h5FFF_FFFF, 1'b1, "R9 sfr top");
    drive(32'h6000_0000, 1'b1, "R10 high base");
    drive(32'hFFFF_FFFF, 1'b1, "R10 top");
    drive(32'h1800_0000, 1'b1, "R11 bank3 single select");
    drive(32'h0, 1'b0, "R1 idle tail");
    drive(32'h0, 1'b0, "R1 idle tail");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule